// File: doc/BRIEF.md
# Frequency Synthesizer Configuration Register Interface

This block holds the programming state of a clock synthesizer: a 9-bit feedback multiplier, a 2-bit output divide select and a 3-bit test-select code. Two paths can write it. The parallel path copies the multiplier and divide-select pins when its load strobe rises. The serial path uses three wires: a clock, a data line and a load strobe. It shifts a 14-bit frame into a shift register on rising serial clock edges. It commits that frame to the configuration when the serial load strobe falls.

All three asynchronous strobes and the serial data line pass through synchronizer chains into one system clock domain. Every edge is detected there. The parallel path wins over the serial path for the multiplier and divide fields. While the parallel strobe is held low, for example during power-up, a serial commit may still change the test-select code, but it cannot change the other two fields. The parallel pins must be stable from before the parallel strobe rises until the commit has completed, which is three system clocks later.

Top module: `pllcfg_top`

## Requirements
- R1: After reset, the multiplier output is all ones (511), the divide select is all ones (3) and the test select is 0. This matches undriven pins with pull-ups.
- R2: A rising edge on `par_load` copies `par_m` and `par_n` into the multiplier and divide outputs within three system clocks.
- R3: Each rising edge of `ser_clk` shifts `ser_data` into the 14-bit shift register. Bits are sent MSB first in the frame order T[2:0], N[1:0], M[8:0]. After 14 shifts the frame bits are therefore [13:11]=T, [10:9]=N and [8:0]=M.
- R4: While `par_load` is high, a falling edge on `ser_load` updates all three outputs from the shift register within three system clocks.
- R5: While `par_load` is low, a falling edge on `ser_load` updates only the test select. The multiplier and divide outputs keep their values.
- R6: If a parallel rising edge and a serial commit are seen in the same cycle, the multiplier and divide outputs take the parallel pins and the test select takes the serial frame.
- R7: Outputs hold their values when no commit edge occurs. This covers serial clock pulses with no load, a rising `ser_load` and a falling `par_load`.
- R8: If more than 14 bits are shifted before a commit, only the last 14 bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_load | input | 1 | Parallel load strobe, commits on rising edge |
| par_m | input | 9 | Parallel multiplier pins |
| par_n | input | 2 | Parallel divide-select pins |
| ser_clk | input | 1 | Serial shift clock, shifts on rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Serial load strobe, commits on falling edge |
| mult_o | output | 9 | Latched feedback multiplier |
| div_sel_o | output | 2 | Latched output divide select |
| test_sel_o | output | 3 | Latched test-select code |

## Verification
The assertions check these properties on every cycle:
- A parallel edge lands the pin values in the outputs.
- A serial commit lands the frame's test field.
- A serial commit with the parallel strobe low leaves the multiplier and divide fields untouched.
- With no commit edge, the outputs do not move.
- Each shift places the synchronized data bit at the shift register's low end.

Only the bench's scenarios show the following:
- The frame's bit order and its field positions, end to end.
- That only the last 14 bits count after an over-long stream.
- The parallel-over-serial outcome when both strobes switch together.
- The reset values.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 3;
    localparam int FRAME_W = T_W + N_W + M_W;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
        logic [T_W-1:0] t;
    } cfg_s;

    localparam cfg_s CFG_RESET = '{m: '1, n: '1, t: '0};
endpackage

// File: rtl/pllcfg_sync.sv
module pllcfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/pllcfg_shift.sv
module pllcfg_shift
    import pllcfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_lvl,
    input  logic               data_raw,
    output logic [FRAME_W-1:0] frame_o
);
    typedef struct packed {
        logic [STAGES-1:0]  dsync;
        logic               sclk_prev;
        logic [FRAME_W-1:0] sr;
    } shf_s;

    shf_s st_d, st_q;
    logic din;
    logic shift_en;

    assign din      = st_q.dsync[STAGES-1];
    assign shift_en = sclk_lvl & ~st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.dsync     = {st_q.dsync[STAGES-2:0], data_raw};
        st_d.sclk_prev = sclk_lvl;
        if (shift_en) st_d.sr = {st_q.sr[FRAME_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_o = st_q.sr;

    AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> st_q.sr[0] == $past(din)); // R3
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.sr)); // R3
endmodule

// File: rtl/pllcfg_regs.sv
module pllcfg_regs
    import pllcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_lvl,
    input  logic               sload_lvl,
    input  logic [M_W-1:0]     par_m,
    input  logic [N_W-1:0]     par_n,
    input  logic [FRAME_W-1:0] frame,
    output cfg_s               cfg_o
);
    typedef struct packed {
        cfg_s cfg;
        logic par_prev;
        logic sload_prev;
    } reg_s;

    reg_s st_d, st_q;
    logic par_edge;
    logic ser_commit;

    assign par_edge   = par_lvl & ~st_q.par_prev;
    assign ser_commit = ~sload_lvl & st_q.sload_prev;

    always_comb begin
        st_d            = st_q;
        st_d.par_prev   = par_lvl;
        st_d.sload_prev = sload_lvl;
        if (ser_commit) begin
            st_d.cfg.t = frame[FRAME_W-1 -: T_W];
            if (par_lvl) begin
                st_d.cfg.n = frame[M_W +: N_W];
                st_d.cfg.m = frame[M_W-1:0];
            end
        end
        if (par_edge) begin
            st_d.cfg.m = par_m;
            st_d.cfg.n = par_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: CFG_RESET, par_prev: 1'b0, sload_prev: 1'b0};
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

    AST_PAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        par_edge |=> (st_q.cfg.m == $past(par_m)) && (st_q.cfg.n == $past(par_n))); // R2
    AST_SER_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        ser_commit |=> st_q.cfg.t == $past(frame[FRAME_W-1 -: T_W])); // R4
    AST_LOW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_commit && !par_lvl) |=> $stable(st_q.cfg.m) && $stable(st_q.cfg.n)); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_edge || ser_commit) |=> $stable(st_q.cfg)); // R7
endmodule

// File: rtl/pllcfg_top.sv
module pllcfg_top
    import pllcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    output logic [M_W-1:0] mult_o,
    output logic [N_W-1:0] div_sel_o,
    output logic [T_W-1:0] test_sel_o
);
    localparam int NUM_STROBES = 3;
    localparam int IDX_PAR     = 0;
    localparam int IDX_SCLK    = 1;
    localparam int IDX_SLOAD   = 2;

    logic [NUM_STROBES-1:0] strobe_raw;
    logic [NUM_STROBES-1:0] strobe_lvl;
    logic [FRAME_W-1:0]     frame;
    cfg_s                   cfg;

    assign strobe_raw = {ser_load, ser_clk, par_load};

    for (genvar gi = 0; gi < NUM_STROBES; gi++) begin : g_sync
        pllcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (strobe_raw[gi]),
            .lvl_o   (strobe_lvl[gi])
        );
    end

    pllcfg_shift #(.STAGES(SYNC_STAGES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_lvl (strobe_lvl[IDX_SCLK]),
        .data_raw (ser_data),
        .frame_o  (frame)
    );

    pllcfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_lvl   (strobe_lvl[IDX_PAR]),
        .sload_lvl (strobe_lvl[IDX_SLOAD]),
        .par_m     (par_m),
        .par_n     (par_n),
        .frame     (frame),
        .cfg_o     (cfg)
    );

    assign mult_o     = cfg.m;
    assign div_sel_o  = cfg.n;
    assign test_sel_o = cfg.t;
endmodule

// File: tb/pllcfg_top_tb.sv
module pllcfg_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load = 1'b0;
    logic [8:0] par_m = '1;
    logic [1:0] par_n = '1;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_load = 1'b0;
    logic [8:0] mult_o;
    logic [1:0] div_sel_o;
    logic [2:0] test_sel_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int exp_m, exp_n, exp_t;

    always #4 clk = ~clk;

    pllcfg_top u_dut (
        .clk(clk), .rst_n(rst_n), .par_load(par_load), .par_m(par_m), .par_n(par_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
        .mult_o(mult_o), .div_sel_o(div_sel_o), .test_sel_o(test_sel_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        check({req, " mult"}, int'(mult_o), exp_m);
        check({req, " div"}, int'(div_sel_o), exp_n);
        check({req, " test"}, int'(test_sel_o), exp_t);
    endtask

    task automatic par_cycle(input int m, input int n);
        par_load = 1'b0;
        tick(4);
        par_m = m[8:0];
        par_n = n[1:0];
        tick(1);
        par_load = 1'b1;
        tick(5);
    endtask

    task automatic shift_bits(input logic [19:0] bits, input int count);
        for (int i = count - 1; i >= 0; i--) begin
            ser_data = bits[i];
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            tick(2);
        end
    endtask

    task automatic ser_commit();
        ser_load = 1'b1;
        tick(4);
        ser_load = 1'b0;
        tick(5);
    endtask

    function automatic logic [13:0] mk_frame(input int t, input int n, input int m);
        return {t[2:0], n[1:0], m[8:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        exp_m = 511; exp_n = 3; exp_t = 0;
        check_all("R1 reset");

        // R2: parallel sweep over every multiplier value
        for (int m = 0; m < 512; m++) begin
            int n = (m ^ (m >> 2)) & 3;
            par_cycle(m, n);
            exp_m = m; exp_n = n;
            check_all("R2 parallel");
        end

        // R3 R4: serial frames over every T and N
        for (int t = 0; t < 8; t++) begin
            for (int n = 0; n < 4; n++) begin
                int m = (t * 67 + n * 29 + 5) % 512;
                shift_bits({6'b0, mk_frame(t, n, m)}, 14);
                ser_commit();
                exp_m = m; exp_n = n; exp_t = t;
                check_all("R3 R4 serial");
            end
        end

        // R8: over-long stream, the last 14 bits win
        shift_bits({6'b101101, mk_frame(5, 2, 300)}, 20);
        ser_commit();
        exp_m = 300; exp_n = 2; exp_t = 5;
        check_all("R8 overlong");

        // R7: serial clock pulses without load
        shift_bits({6'b0, mk_frame(1, 1, 77)}, 14);
        check_all("R7 shift no load");
        // R7: rising ser_load only
        ser_load = 1'b1;
        tick(6);
        check_all("R7 sload rise");
        ser_load = 1'b0;
        tick(5);
        exp_m = 77; exp_n = 1; exp_t = 1;
        check_all("R4 commit after hold");
        // R7: falling par_load with changed pins
        par_m = 9'd123; par_n = 2'd0;
        tick(1);
        par_load = 1'b0;
        tick(6);
        check_all("R7 par fall");

        // R5: par_load low, serial commit changes only T
        shift_bits({6'b0, mk_frame(6, 3, 400)}, 14);
        ser_commit();
        exp_t = 6;
        check_all("R5 low block");
        par_m = 9'd77; par_n = 2'd1;
        tick(1);
        par_load = 1'b1;
        tick(5);
        check_all("R5 restore");

        // R6: parallel rise and serial commit together
        par_load = 1'b0;
        tick(5);
        shift_bits({6'b0, mk_frame(3, 0, 17)}, 14);
        par_m = 9'd450; par_n = 2'd2;
        ser_load = 1'b1;
        tick(4);
        ser_load = 1'b0;
        par_load = 1'b1;
        tick(5);
        exp_m = 450; exp_n = 2; exp_t = 3;
        check_all("R6 priority");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule